// File: doc/BRIEF.md
# Micro-TLB Pair with Deferred Invalidation

This block holds two small fully associative translation caches that sit in front of a larger set-associative joint TLB. One cache serves instruction fetches and the other serves data accesses. A lookup that hits returns its translation combinationally, in the same cycle as the request. A lookup that misses opens a refill toward the joint TLB. When the joint TLB answers, the returned translation is installed, so the requester's next lookup hits.

The two caches are cleared only in response to joint-TLB maintenance commands, and the command opcode decides which ones clear them. A plain joint-TLB write clears both caches. A write-keep leaves them intact, so an entry that the joint TLB has just evicted can still serve lookups. An explicit invalidate command clears both caches, but only when the joint TLB's index register does not hold a lookup error. A probe never affects the caches. A refill that is still in flight when a clear takes effect is dropped.

A debug port reads back any entry of either cache through a linear index. Instruction entries appear at 0x200 upward and data entries at 0x400 upward.

Top module: `utlb_pair`

## Requirements
- R1: After reset, every entry of both caches is invalid, both refill requests are low, and every lookup misses.
- R2: A lookup whose tag matches a valid entry sets the hit output and presents that entry's data in the same cycle, with no clock edge in between.
- R3: A missing lookup on a side with no refill outstanding raises that side's refill request after the next clock edge, carrying the missed tag. The request and its tag hold until a response arrives. Further misses on that side neither change the tag nor open a second refill.
- R4: A refill response with found=1 installs the returned data under the requested tag. A response with found=0 installs nothing. Either response ends the refill.
- R5: The instruction cache has 4 entries and the data cache has 8. A new entry goes to the first invalid slot, searching round-robin from a pointer. If no slot is invalid, it goes to the pointer's slot. The pointer then moves to the slot after the one filled. A clear returns the pointer to slot 0.
- R6: Command opcode 0 (joint-TLB write) clears every entry of both caches.
- R7: Command opcode 1 (write-keep) and opcode 3 (probe) leave the contents of both caches unchanged.
- R8: Command opcode 2 (invalidate) clears both caches when idx_err_i is 0. It has no effect when idx_err_i is 1.
- R9: If a clear takes effect while a refill is outstanding, that refill's response installs nothing, even when found=1.
- R10: Debug index 0x200+k reads instruction entry k (k=0..3) and 0x400+k reads data entry k (k=0..7). dbg_vld_o is the entry's valid bit. Any other index returns dbg_vld_o=0 with zero tag and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ilk_req_i | input | 1 | Instruction lookup request |
| ilk_tag_i | input | TAG_W | Instruction lookup tag (page number and address-space id) |
| ilk_hit_o | output | 1 | Instruction lookup hit |
| ilk_data_o | output | DATA_W | Instruction translation on hit, else zero |
| ifill_req_o | output | 1 | Instruction refill outstanding |
| ifill_tag_o | output | TAG_W | Tag being refilled for instructions |
| ifill_rsp_i | input | 1 | Joint TLB response for the instruction refill |
| ifill_found_i | input | 1 | Joint TLB held the requested translation |
| ifill_data_i | input | DATA_W | Returned instruction translation |
| dlk_req_i | input | 1 | Data lookup request |
| dlk_tag_i | input | TAG_W | Data lookup tag |
| dlk_hit_o | output | 1 | Data lookup hit |
| dlk_data_o | output | DATA_W | Data translation on hit, else zero |
| dfill_req_o | output | 1 | Data refill outstanding |
| dfill_tag_o | output | TAG_W | Tag being refilled for data |
| dfill_rsp_i | input | 1 | Joint TLB response for the data refill |
| dfill_found_i | input | 1 | Joint TLB held the requested translation |
| dfill_data_i | input | DATA_W | Returned data translation |
| cmd_vld_i | input | 1 | Joint-TLB command strobe, one cycle |
| cmd_op_i | input | 2 | Opcode: 0 write, 1 write-keep, 2 invalidate, 3 probe |
| idx_err_i | input | 1 | Joint-TLB index register holds a lookup error |
| dbg_idx_i | input | DBG_W | Debug read index |
| dbg_vld_o | output | 1 | Valid bit of the addressed entry |
| dbg_tag_o | output | TAG_W | Tag of the addressed entry |
| dbg_data_o | output | DATA_W | Data of the addressed entry |

## Verification
The assertions assume the joint TLB responds only while the matching refill request is high, and that a response lasts exactly one cycle. They also assume every command strobe lasts one cycle. The stimulus honours both assumptions by construction. It reads the refill request and tag at a falling edge before it drives a single-cycle response, and every command is a one-cycle pulse. Lookups are held only for the cycle in which they are scored, so a lookup never overlaps a response for the same tag.

// File: rtl/utlb_pkg.sv
package utlb_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  typedef enum logic [1:0] {
    CMD_WR      = 2'd0,
    CMD_WR_KEEP = 2'd1,
    CMD_UINV    = 2'd2,
    CMD_PROBE   = 2'd3
  } utlb_cmd_e;
endpackage

// File: rtl/utlb_store.sv
module utlb_store #(
  parameter int N      = 4,
  parameter int TAG_W  = 20,
  parameter int DATA_W = 24,
  localparam int IW    = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic [TAG_W-1:0]  lk_tag_i,
  output logic              lk_hit_o,
  output logic [DATA_W-1:0] lk_data_o,
  input  logic              inst_i,
  input  logic [TAG_W-1:0]  inst_tag_i,
  input  logic [DATA_W-1:0] inst_data_i,
  input  logic [IW-1:0]     rd_idx_i,
  output logic              rd_vld_o,
  output logic [TAG_W-1:0]  rd_tag_o,
  output logic [DATA_W-1:0] rd_data_o
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [N-1:0]      vld_q;
  logic [TAG_W-1:0]  tag_q  [N];
  logic [DATA_W-1:0] data_q [N];
  logic [IW-1:0]     rr_q, victim;
  logic [N-1:0]      match;
  logic              found;

  always_comb begin
    lk_data_o = '0;
    for (int k = 0; k < N; k++) begin
      match[k] = vld_q[k] && (tag_q[k] == lk_tag_i);
      if (match[k]) lk_data_o = lk_data_o | data_q[k];
    end
    lk_hit_o = |match;
  end

  // first invalid slot from the pointer, else the pointer itself
  always_comb begin
    victim = rr_q;
    found  = 1'b0;
    for (int k = 0; k < N; k++) begin
      if (!found && !vld_q[(int'(rr_q) + k) % N]) begin
        victim = IW'((int'(rr_q) + k) % N);
        found  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      rr_q  <= '0;
    end else if (flush_i) begin
      vld_q <= '0;
      rr_q  <= '0;
    end else if (inst_i) begin
      vld_q[victim] <= 1'b1;
      rr_q          <= IW'((int'(victim) + 1) % N);
    end
  end

  always_ff @(posedge clk_i) begin
    if (inst_i && !flush_i) begin
      tag_q[victim]  <= inst_tag_i;
      data_q[victim] <= inst_data_i;
    end
  end

  assign rd_vld_o  = vld_q[rd_idx_i];
  assign rd_tag_o  = tag_q[rd_idx_i];
  assign rd_data_o = data_q[rd_idx_i];

  // R5
  no_dup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(match));

  // R6
  flush_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (vld_q == '0));

  // R4
  install_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inst_i && !flush_i) |=> (vld_q[$past(victim)] && tag_q[$past(victim)] == $past(inst_tag_i)));
endmodule

// File: rtl/utlb_fill.sv
module utlb_fill #(
  parameter int TAG_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             lk_req_i,
  input  logic             lk_hit_i,
  input  logic [TAG_W-1:0] lk_tag_i,
  input  logic             rsp_i,
  input  logic             found_i,
  output logic             req_o,
  output logic [TAG_W-1:0] tag_o,
  output logic             install_o
);
  timeunit 1ns;
  timeprecision 1ps;

  logic             pend_q, stale_q;
  logic [TAG_W-1:0] tag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      stale_q <= 1'b0;
      tag_q   <= '0;
    end else if (pend_q && rsp_i) begin
      pend_q  <= 1'b0;
      stale_q <= 1'b0;
    end else if (!pend_q && lk_req_i && !lk_hit_i) begin
      pend_q  <= 1'b1;
      stale_q <= flush_i;
      tag_q   <= lk_tag_i;
    end else if (pend_q && flush_i) begin
      stale_q <= 1'b1;
    end
  end

  assign req_o     = pend_q;
  assign tag_o     = tag_q;
  assign install_o = pend_q && rsp_i && found_i && !stale_q && !flush_i;

  // R3
  fill_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !rsp_i) |=> (req_o && $stable(tag_o)));

  // R9
  stale_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && flush_i) |=> !install_o);

  // R9
  same_cycle_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |-> !install_o);
endmodule

// File: rtl/utlb_side.sv
module utlb_side #(
  parameter int N      = 4,
  parameter int TAG_W  = 20,
  parameter int DATA_W = 24,
  localparam int IW    = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              lk_req_i,
  input  logic [TAG_W-1:0]  lk_tag_i,
  output logic              lk_hit_o,
  output logic [DATA_W-1:0] lk_data_o,
  output logic              fill_req_o,
  output logic [TAG_W-1:0]  fill_tag_o,
  input  logic              fill_rsp_i,
  input  logic              fill_found_i,
  input  logic [DATA_W-1:0] fill_data_i,
  input  logic [IW-1:0]     rd_idx_i,
  output logic              rd_vld_o,
  output logic [TAG_W-1:0]  rd_tag_o,
  output logic [DATA_W-1:0] rd_data_o
);
  timeunit 1ns;
  timeprecision 1ps;

  logic              hit_raw, install;
  logic [DATA_W-1:0] data_raw;

  utlb_store #(.N(N), .TAG_W(TAG_W), .DATA_W(DATA_W)) i_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (flush_i),
    .lk_tag_i    (lk_tag_i),
    .lk_hit_o    (hit_raw),
    .lk_data_o   (data_raw),
    .inst_i      (install),
    .inst_tag_i  (fill_tag_o),
    .inst_data_i (fill_data_i),
    .rd_idx_i    (rd_idx_i),
    .rd_vld_o    (rd_vld_o),
    .rd_tag_o    (rd_tag_o),
    .rd_data_o   (rd_data_o)
  );

  utlb_fill #(.TAG_W(TAG_W)) i_fill (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .flush_i   (flush_i),
    .lk_req_i  (lk_req_i),
    .lk_hit_i  (hit_raw),
    .lk_tag_i  (lk_tag_i),
    .rsp_i     (fill_rsp_i),
    .found_i   (fill_found_i),
    .req_o     (fill_req_o),
    .tag_o     (fill_tag_o),
    .install_o (install)
  );

  assign lk_hit_o  = lk_req_i && hit_raw;
  assign lk_data_o = lk_hit_o ? data_raw : '0;
endmodule

// File: rtl/utlb_pair.sv
module utlb_pair import utlb_pkg::*; #(
  parameter int TAG_W  = 20,
  parameter int DATA_W = 24,
  parameter int I_N    = 4,
  parameter int D_N    = 8,
  parameter int DBG_W  = 12,
  parameter int I_BASE = 'h200,
  parameter int D_BASE = 'h400,
  localparam int I_IW  = (I_N > 1) ? $clog2(I_N) : 1,
  localparam int D_IW  = (D_N > 1) ? $clog2(D_N) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ilk_req_i,
  input  logic [TAG_W-1:0]  ilk_tag_i,
  output logic              ilk_hit_o,
  output logic [DATA_W-1:0] ilk_data_o,
  output logic              ifill_req_o,
  output logic [TAG_W-1:0]  ifill_tag_o,
  input  logic              ifill_rsp_i,
  input  logic              ifill_found_i,
  input  logic [DATA_W-1:0] ifill_data_i,
  input  logic              dlk_req_i,
  input  logic [TAG_W-1:0]  dlk_tag_i,
  output logic              dlk_hit_o,
  output logic [DATA_W-1:0] dlk_data_o,
  output logic              dfill_req_o,
  output logic [TAG_W-1:0]  dfill_tag_o,
  input  logic              dfill_rsp_i,
  input  logic              dfill_found_i,
  input  logic [DATA_W-1:0] dfill_data_i,
  input  logic              cmd_vld_i,
  input  logic [1:0]        cmd_op_i,
  input  logic              idx_err_i,
  input  logic [DBG_W-1:0]  dbg_idx_i,
  output logic              dbg_vld_o,
  output logic [TAG_W-1:0]  dbg_tag_o,
  output logic [DATA_W-1:0] dbg_data_o
);
  timeunit 1ns;
  timeprecision 1ps;

  utlb_cmd_e         op;
  logic              flush, i_sel, d_sel;
  logic              i_rd_vld, d_rd_vld;
  logic [TAG_W-1:0]  i_rd_tag, d_rd_tag;
  logic [DATA_W-1:0] i_rd_data, d_rd_data;

  assign op    = utlb_cmd_e'(cmd_op_i);
  // write clears; invalidate clears only with a usable index register
  assign flush = cmd_vld_i && ((op == CMD_WR) || ((op == CMD_UINV) && !idx_err_i));

  assign i_sel = (int'(dbg_idx_i) >= I_BASE) && (int'(dbg_idx_i) < I_BASE + I_N);
  assign d_sel = (int'(dbg_idx_i) >= D_BASE) && (int'(dbg_idx_i) < D_BASE + D_N);

  utlb_side #(.N(I_N), .TAG_W(TAG_W), .DATA_W(DATA_W)) i_side_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .flush_i      (flush),
    .lk_req_i     (ilk_req_i),
    .lk_tag_i     (ilk_tag_i),
    .lk_hit_o     (ilk_hit_o),
    .lk_data_o    (ilk_data_o),
    .fill_req_o   (ifill_req_o),
    .fill_tag_o   (ifill_tag_o),
    .fill_rsp_i   (ifill_rsp_i),
    .fill_found_i (ifill_found_i),
    .fill_data_i  (ifill_data_i),
    .rd_idx_i     (I_IW'(dbg_idx_i - DBG_W'(I_BASE))),
    .rd_vld_o     (i_rd_vld),
    .rd_tag_o     (i_rd_tag),
    .rd_data_o    (i_rd_data)
  );

  utlb_side #(.N(D_N), .TAG_W(TAG_W), .DATA_W(DATA_W)) i_side_d (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .flush_i      (flush),
    .lk_req_i     (dlk_req_i),
    .lk_tag_i     (dlk_tag_i),
    .lk_hit_o     (dlk_hit_o),
    .lk_data_o    (dlk_data_o),
    .fill_req_o   (dfill_req_o),
    .fill_tag_o   (dfill_tag_o),
    .fill_rsp_i   (dfill_rsp_i),
    .fill_found_i (dfill_found_i),
    .fill_data_i  (dfill_data_i),
    .rd_idx_i     (D_IW'(dbg_idx_i - DBG_W'(D_BASE))),
    .rd_vld_o     (d_rd_vld),
    .rd_tag_o     (d_rd_tag),
    .rd_data_o    (d_rd_data)
  );

  always_comb begin
    dbg_vld_o  = 1'b0;
    dbg_tag_o  = '0;
    dbg_data_o = '0;
    if (i_sel) begin
      dbg_vld_o  = i_rd_vld;
      dbg_tag_o  = i_rd_tag;
      dbg_data_o = i_rd_data;
    end else if (d_sel) begin
      dbg_vld_o  = d_rd_vld;
      dbg_tag_o  = d_rd_tag;
      dbg_data_o = d_rd_data;
    end
  end

  // R8
  inv_blocked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_vld_i && cmd_op_i == 2'd2 && idx_err_i && ilk_req_i && ilk_hit_o)
      |=> (ilk_req_i && ilk_tag_i == $past(ilk_tag_i)) |-> ilk_hit_o);
endmodule

// File: tb/test_utlb_pair.sv
module test_utlb_pair;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int TW = 20;
  localparam int DW = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ilk_req = 1'b0, dlk_req = 1'b0;
  logic [TW-1:0] ilk_tag = '0, dlk_tag = '0;
  logic          ilk_hit, dlk_hit;
  logic [DW-1:0] ilk_data, dlk_data;
  logic          ifill_req, dfill_req;
  logic [TW-1:0] ifill_tag, dfill_tag;
  logic          ifill_rsp = 1'b0, dfill_rsp = 1'b0;
  logic          ifill_found = 1'b0, dfill_found = 1'b0;
  logic [DW-1:0] ifill_data = '0, dfill_data = '0;
  logic          cmd_vld = 1'b0;
  logic [1:0]    cmd_op = '0;
  logic          idx_err = 1'b0;
  logic [11:0]   dbg_idx = '0;
  logic          dbg_vld;
  logic [TW-1:0] dbg_tag;
  logic [DW-1:0] dbg_data;

  always #2.5 clk = ~clk;

  utlb_pair i_utlb_pair (
    .clk_i(clk), .rst_ni(rst_n),
    .ilk_req_i(ilk_req), .ilk_tag_i(ilk_tag), .ilk_hit_o(ilk_hit), .ilk_data_o(ilk_data),
    .ifill_req_o(ifill_req), .ifill_tag_o(ifill_tag), .ifill_rsp_i(ifill_rsp),
    .ifill_found_i(ifill_found), .ifill_data_i(ifill_data),
    .dlk_req_i(dlk_req), .dlk_tag_i(dlk_tag), .dlk_hit_o(dlk_hit), .dlk_data_o(dlk_data),
    .dfill_req_o(dfill_req), .dfill_tag_o(dfill_tag), .dfill_rsp_i(dfill_rsp),
    .dfill_found_i(dfill_found), .dfill_data_i(dfill_data),
    .cmd_vld_i(cmd_vld), .cmd_op_i(cmd_op), .idx_err_i(idx_err),
    .dbg_idx_i(dbg_idx), .dbg_vld_o(dbg_vld), .dbg_tag_o(dbg_tag), .dbg_data_o(dbg_data)
  );

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic          hit;
    logic [DW-1:0] data;
    string         rq;
  } exp_t;
  exp_t q_i[$];
  exp_t q_d[$];

  // reference model
  logic [TW-1:0] m_tag  [2][8];
  bit            m_vld  [2][8];
  int            m_rr   [2];
  bit            m_pend [2];
  bit            m_stale[2];
  logic [TW-1:0] m_ptag [2];
  int            m_n    [2] = '{4, 8};

  function automatic logic [DW-1:0] jdata(logic [TW-1:0] t);
    return {4'hC, t ^ 20'h35A5A};
  endfunction

  function automatic int m_find(int s, logic [TW-1:0] t);
    for (int k = 0; k < m_n[s]; k++)
      if (m_vld[s][k] && m_tag[s][k] == t) return k;
    return -1;
  endfunction

  task automatic chk(string rq, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // monitor: score lookups against queued expectations
  always @(negedge clk) begin
    #1;
    if (ilk_req && q_i.size() > 0) begin
      exp_t e;
      e = q_i.pop_front();
      chk(e.rq, "i hit", 64'(ilk_hit), 64'(e.hit));
      if (e.hit) chk(e.rq, "i data", 64'(ilk_data), 64'(e.data));
    end
    if (dlk_req && q_d.size() > 0) begin
      exp_t e;
      e = q_d.pop_front();
      chk(e.rq, "d hit", 64'(dlk_hit), 64'(e.hit));
      if (e.hit) chk(e.rq, "d data", 64'(dlk_data), 64'(e.data));
    end
  end

  task automatic lookup(int s, logic [TW-1:0] t, string rq);
    exp_t e;
    @(negedge clk);
    if (s == 0) begin ilk_req = 1'b1; ilk_tag = t; end
    else        begin dlk_req = 1'b1; dlk_tag = t; end
    e.hit  = (m_find(s, t) >= 0);
    e.data = jdata(t);
    e.rq   = rq;
    if (s == 0) q_i.push_back(e); else q_d.push_back(e);
    if (!e.hit && !m_pend[s]) begin
      m_pend[s]  = 1'b1;
      m_ptag[s]  = t;
      m_stale[s] = 1'b0;
    end
    @(posedge clk);
    #1;
    ilk_req = 1'b0;
    dlk_req = 1'b0;
  endtask

  task automatic respond(int s, bit found, string rq);
    @(negedge clk);
    chk(rq, "fill req", 64'(s == 0 ? ifill_req : dfill_req), 64'(1));
    chk(rq, "fill tag", 64'(s == 0 ? ifill_tag : dfill_tag), 64'(m_ptag[s]));
    if (s == 0) begin ifill_rsp = 1'b1; ifill_found = found; ifill_data = jdata(m_ptag[s]); end
    else        begin dfill_rsp = 1'b1; dfill_found = found; dfill_data = jdata(m_ptag[s]); end
    if (found && !m_stale[s]) begin
      int v;
      bit got;
      v = m_rr[s];
      got = 1'b0;
      for (int k = 0; k < m_n[s]; k++) begin
        if (!got && !m_vld[s][(m_rr[s] + k) % m_n[s]]) begin
          v = (m_rr[s] + k) % m_n[s];
          got = 1'b1;
        end
      end
      m_tag[s][v] = m_ptag[s];
      m_vld[s][v] = 1'b1;
      m_rr[s]     = (v + 1) % m_n[s];
    end
    m_pend[s] = 1'b0;
    @(posedge clk);
    #1;
    ifill_rsp = 1'b0;
    dfill_rsp = 1'b0;
  endtask

  task automatic command(logic [1:0] op, bit err);
    @(negedge clk);
    cmd_vld = 1'b1;
    cmd_op  = op;
    idx_err = err;
    if (op == 2'd0 || (op == 2'd2 && !err)) begin
      for (int s = 0; s < 2; s++) begin
        for (int k = 0; k < 8; k++) m_vld[s][k] = 1'b0;
        m_rr[s] = 0;
        if (m_pend[s]) m_stale[s] = 1'b1;
      end
    end
    @(posedge clk);
    #1;
    cmd_vld = 1'b0;
    idx_err = 1'b0;
  endtask

  task automatic dbg(int idx, string rq);
    int s, e;
    s = -1;
    e = 0;
    @(negedge clk);
    dbg_idx = 12'(idx);
    #1;
    if (idx >= 'h200 && idx < 'h204) begin s = 0; e = idx - 'h200; end
    if (idx >= 'h400 && idx < 'h408) begin s = 1; e = idx - 'h400; end
    if (s < 0) begin
      chk(rq, "dbg vld", 64'(dbg_vld), 64'(0));
      chk(rq, "dbg tag", 64'(dbg_tag), 64'(0));
      chk(rq, "dbg data", 64'(dbg_data), 64'(0));
    end else begin
      chk(rq, "dbg vld", 64'(dbg_vld), 64'(m_vld[s][e]));
      if (m_vld[s][e]) begin
        chk(rq, "dbg tag", 64'(dbg_tag), 64'(m_tag[s][e]));
        chk(rq, "dbg data", 64'(dbg_data), 64'(jdata(m_tag[s][e])));
      end
    end
  endtask

  task automatic fill(int s, logic [TW-1:0] t, string rq);
    lookup(s, t, rq);
    respond(s, 1'b1, rq);
    lookup(s, t, rq);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    for (int s = 0; s < 2; s++) begin
      for (int k = 0; k < 8; k++) begin m_vld[s][k] = 1'b0; m_tag[s][k] = '0; end
      m_rr[s] = 0; m_pend[s] = 1'b0; m_stale[s] = 1'b0; m_ptag[s] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    @(negedge clk);
    chk("R1", "ifill req", 64'(ifill_req), 64'(0));
    chk("R1", "dfill req", 64'(dfill_req), 64'(0));
    dbg('h200, "R1");
    dbg('h407, "R1");
    lookup(0, 20'h0A001, "R1");
    // R3: request held with its tag while no response comes
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R3", "dfill idle", 64'(dfill_req), 64'(0));
    respond(0, 1'b1, "R3");
    @(negedge clk);
    chk("R3", "ifill drop", 64'(ifill_req), 64'(0));
    lookup(0, 20'h0A001, "R2");
    // R5: fill all four then replace slot 0
    fill(0, 20'h0B002, "R5");
    fill(0, 20'h0C003, "R5");
    fill(0, 20'h0D004, "R5");
    fill(0, 20'h0E005, "R5");
    dbg('h200, "R5");
    dbg('h203, "R5");
    lookup(0, 20'h0A001, "R5");
    // R4: not-found response installs nothing
    respond(0, 1'b0, "R4");
    lookup(0, 20'h0A001, "R4");
    respond(0, 1'b0, "R4");
    lookup(0, 20'h0B002, "R4");
    // R10: data side and debug index map
    fill(1, 20'h1F010, "R10");
    fill(1, 20'h1F020, "R10");
    fill(1, 20'h1F030, "R10");
    dbg('h400, "R10");
    dbg('h402, "R10");
    dbg('h403, "R10");
    dbg('h300, "R10");
    dbg('h408, "R10");
    dbg('h204, "R10");
    // R7: write-keep and probe keep contents
    command(2'd1, 1'b0);
    command(2'd3, 1'b0);
    lookup(0, 20'h0E005, "R7");
    lookup(1, 20'h1F010, "R7");
    dbg('h401, "R7");
    // R8: invalidate blocked by index error, then effective
    command(2'd2, 1'b1);
    lookup(0, 20'h0E005, "R8");
    lookup(1, 20'h1F020, "R8");
    command(2'd2, 1'b0);
    lookup(0, 20'h0E005, "R8");
    respond(0, 1'b0, "R8");
    lookup(1, 20'h1F020, "R8");
    respond(1, 1'b0, "R8");
    dbg('h400, "R8");
    // R6: write clears, pointer back to slot 0
    fill(0, 20'h0B002, "R6");
    fill(1, 20'h1F040, "R6");
    command(2'd0, 1'b0);
    dbg('h200, "R6");
    lookup(1, 20'h1F040, "R6");
    respond(1, 1'b0, "R6");
    fill(0, 20'h0C003, "R5");
    dbg('h200, "R5");
    // R9: refill in flight at invalidate is dropped
    lookup(1, 20'h1F050, "R9");
    lookup(1, 20'h1F060, "R3");
    @(negedge clk);
    chk("R3", "single outstanding tag", 64'(dfill_tag), 64'(20'h1F050));
    command(2'd2, 1'b0);
    respond(1, 1'b1, "R9");
    lookup(1, 20'h1F050, "R9");
    dbg('h400, "R9");
    respond(1, 1'b1, "R9");
    lookup(1, 20'h1F050, "R9");
    repeat (3) @(posedge clk);
    report();
  end
endmodule